// File: doc/BRIEF.md
# Contact Bounce Measurement Peripheral

This block watches a vector of raw push-button or switch inputs and measures how much they chatter. Each raw line is brought into the clock domain through a two-stage synchronizer. Every change on every line then adds to a transition tally. A second tally records how many clock ticks separate the first change seen after a clear from the most recent change. Together the two numbers describe how many bounces a press produced and how long the bouncing lasted.

Both tallies can be read as 32-bit words on a small strobe/acknowledge register slave. The already-debounced button levels, supplied by a separate debouncer, can be read there too. A host clears both tallies by writing any value to either tally word. The usual sequence is: clear, press a button, then read the two words.

Both tallies saturate at their all-ones value rather than wrapping. The bus interface answers every strobe with an acknowledge one clock later, together with registered read data.

Top module: `bounce_meter`

## Requirements
- R1: After reset both tallies are zero, `wb_ack` is low and `wb_rdata` is zero.
- R2: A read of word index 6 returns the transition tally, zero-extended to 32 bits. The tally grows by the number of input bits that changed, so several bits toggling in one cycle each count.
- R3: A read of word index 7 returns the duration tally. This is the number of clock ticks from the first input change after a clear (or reset) to the latest change. After a single change it is zero.
- R4: A strobed write (`wb_stb`=1, `wb_we`=1) to word index 6 or 7 zeroes both tallies, effective on the next clock. A strobed write to any other index leaves both tallies unchanged.
- R5: A read of word index 8 returns `btn_level` zero-extended to 32 bits.
- R6: A read of any word index other than 6, 7 and 8 returns zero.
- R7: `wb_ack` is high in exactly the cycle after each strobed cycle. It carries the read data selected by that strobe, and zero for a write.
- R8: Neither tally wraps. Each one stops at 2^CNT_W-1 while changes continue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_stb | input | 1 | Bus strobe, one transfer per high cycle |
| wb_we | input | 1 | Write enable qualifying the strobe |
| wb_addr | input | ADDR_W | Word index (byte offset divided by four) |
| btn_raw | input | NUM_IN | Raw, unsynchronized button lines |
| btn_level | input | NUM_IN | Debounced button levels from an external debouncer |
| wb_ack | output | 1 | Acknowledge, one clock after the strobe |
| wb_rdata | output | 32 | Registered read data |

## Verification
A wrong edge detector or synchronizer would show up as a wrong transition tally at index 6. This appears on the first read made at least three clocks after a toggle. A duration register that starts late or fails to extend would give a tick count at index 7 that differs from the known spacing of the toggles. A clear that fails to reach both tallies, or that fires on an unrelated write, would show on the read immediately after the write. A second instance with 4-bit tallies checks that saturation holds at 15 instead of wrapping.

// File: rtl/bounce_meter_pkg.sv
package bounce_meter_pkg;

    localparam int unsigned BUS_W     = 32;
    localparam int unsigned IDX_TRANS = 6;
    localparam int unsigned IDX_DUR   = 7;
    localparam int unsigned IDX_LEVEL = 8;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_TRANS,
        SEL_DUR,
        SEL_LEVEL
    } reg_sel_e;

    typedef struct packed {
        logic     stb;
        logic     we;
        reg_sel_e sel;
    } bus_req_t;

    function automatic reg_sel_e decode_sel(input logic [31:0] idx);
        case (idx)
            IDX_TRANS: return SEL_TRANS;
            IDX_DUR:   return SEL_DUR;
            IDX_LEVEL: return SEL_LEVEL;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/bm_sync_edge.sv
module bm_sync_edge #(
    parameter int NUM_IN = 4,
    localparam int NC_W  = $clog2(NUM_IN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] raw,
    output logic [NC_W-1:0]   n_changes
);

    logic [NUM_IN-1:0] meta_q;
    logic [NUM_IN-1:0] sync_q;
    logic [NUM_IN-1:0] prev_q;
    logic [NUM_IN-1:0] diff;

    // Two-stage synchronizer followed by one history stage per line
    for (genvar g = 0; g < NUM_IN; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[g] <= 1'b0;
                sync_q[g] <= 1'b0;
                prev_q[g] <= 1'b0;
            end else begin
                meta_q[g] <= raw[g];
                sync_q[g] <= meta_q[g];
                prev_q[g] <= sync_q[g];
            end
        end
        assign diff[g] = sync_q[g] ^ prev_q[g];
    end

    always_comb begin
        n_changes = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            n_changes = n_changes + NC_W'(diff[i]);
        end
    end

endmodule

// File: rtl/bm_counters.sv
module bm_counters #(
    parameter int NUM_IN = 4,
    parameter int CNT_W  = 31,
    localparam int NC_W  = $clog2(NUM_IN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [NC_W-1:0]  n_changes,
    output logic [CNT_W-1:0] trans_cnt,
    output logic [CNT_W-1:0] dur_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] elapsed_q;
    logic             running_q;
    logic [CNT_W:0]   trans_sum;
    logic [CNT_W-1:0] trans_next;
    logic [CNT_W-1:0] elapsed_inc;

    always_comb begin
        trans_sum   = {1'b0, trans_cnt} + (CNT_W+1)'(n_changes);
        trans_next  = trans_sum[CNT_W] ? CNT_MAX : trans_sum[CNT_W-1:0];
        elapsed_inc = (elapsed_q == CNT_MAX) ? CNT_MAX : elapsed_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            trans_cnt <= '0;
            dur_cnt   <= '0;
            elapsed_q <= '0;
            running_q <= 1'b0;
        end else begin
            if (n_changes != '0) begin
                trans_cnt <= trans_next;
            end
            if (running_q) begin
                elapsed_q <= elapsed_inc;
            end
            if (n_changes != '0) begin
                if (!running_q) begin
                    running_q <= 1'b1;
                end else begin
                    dur_cnt <= elapsed_inc;
                end
            end
        end
    end

endmodule

// File: rtl/bm_regfile.sv
module bm_regfile
    import bounce_meter_pkg::*;
#(
    parameter int NUM_IN = 4,
    parameter int CNT_W  = 31,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  trans_cnt,
    input  logic [CNT_W-1:0]  dur_cnt,
    input  logic [NUM_IN-1:0] level,
    output logic              clr,
    output logic              ack,
    output logic [BUS_W-1:0]  rdata
);

    bus_req_t         req;
    logic [BUS_W-1:0] rd_mux;

    always_comb begin
        req.stb = stb;
        req.we  = we;
        req.sel = decode_sel(32'(addr));
    end

    assign clr = req.stb && req.we && (req.sel == SEL_TRANS || req.sel == SEL_DUR);

    always_comb begin
        case (req.sel)
            SEL_TRANS: rd_mux = BUS_W'(trans_cnt);
            SEL_DUR:   rd_mux = BUS_W'(dur_cnt);
            SEL_LEVEL: rd_mux = BUS_W'(level);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack   <= 1'b0;
            rdata <= '0;
        end else begin
            ack   <= req.stb;
            rdata <= (req.stb && !req.we) ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/bounce_meter.sv
module bounce_meter
    import bounce_meter_pkg::*;
#(
    parameter int NUM_IN = 4,
    parameter int CNT_W  = 31,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_stb,
    input  logic              wb_we,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [NUM_IN-1:0] btn_raw,
    input  logic [NUM_IN-1:0] btn_level,
    output logic              wb_ack,
    output logic [31:0]       wb_rdata
);

    localparam int NC_W = $clog2(NUM_IN + 1);

    logic [NC_W-1:0]  n_changes;
    logic [CNT_W-1:0] trans_q;
    logic [CNT_W-1:0] dur_q;
    logic             clr;

    bm_sync_edge #(.NUM_IN(NUM_IN)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .raw       (btn_raw),
        .n_changes (n_changes)
    );

    bm_counters #(.NUM_IN(NUM_IN), .CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .n_changes (n_changes),
        .trans_cnt (trans_q),
        .dur_cnt   (dur_q)
    );

    bm_regfile #(.NUM_IN(NUM_IN), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .stb       (wb_stb),
        .we        (wb_we),
        .addr      (wb_addr),
        .trans_cnt (trans_q),
        .dur_cnt   (dur_q),
        .level     (btn_level),
        .clr       (clr),
        .ack       (wb_ack),
        .rdata     (wb_rdata)
    );

endmodule

// File: rtl/bounce_meter_chk.sv
module bounce_meter_chk #(
    parameter int CNT_W  = 31,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wb_stb,
    input logic              wb_we,
    input logic [ADDR_W-1:0] wb_addr,
    input logic              wb_ack,
    input logic [31:0]       wb_rdata,
    input logic [CNT_W-1:0]  trans_q,
    input logic [CNT_W-1:0]  dur_q
);

    logic hit_cnt_word;
    logic hit_mapped;
    assign hit_cnt_word = (32'(wb_addr) == 32'd6) || (32'(wb_addr) == 32'd7);
    assign hit_mapped   = hit_cnt_word || (32'(wb_addr) == 32'd8);

    // R7: acknowledge follows each strobe by one clock
    a_r7_ack_after_stb: assert property (@(posedge clk) disable iff (rst)
        wb_stb |=> wb_ack);
    a_r7_no_stray_ack: assert property (@(posedge clk) disable iff (rst)
        !wb_stb |=> !wb_ack);

    // R4: write to a tally word zeroes both tallies
    a_r4_clear_both: assert property (@(posedge clk) disable iff (rst)
        (wb_stb && wb_we && hit_cnt_word) |=> (trans_q == '0 && dur_q == '0));

    // R8: without a clear, tallies never decrease (no wrap)
    a_r8_trans_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !(wb_stb && wb_we && hit_cnt_word) |=> trans_q >= $past(trans_q));
    a_r8_dur_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !(wb_stb && wb_we && hit_cnt_word) |=> dur_q >= $past(dur_q));

    // R6: unmapped reads return zero
    a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (wb_stb && !wb_we && !hit_mapped) |=> wb_rdata == 32'd0);

endmodule

bind bounce_meter bounce_meter_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wb_stb   (wb_stb),
    .wb_we    (wb_we),
    .wb_addr  (wb_addr),
    .wb_ack   (wb_ack),
    .wb_rdata (wb_rdata),
    .trans_q  (trans_q),
    .dur_q    (dur_q)
);

// File: tb/bounce_meter_tb.sv
`timescale 1ns/1ps
module bounce_meter_tb;

    localparam int NUM_IN = 4;
    localparam int ADDR_W = 4;
    localparam int SAT_W  = 4;
    localparam longint SAT_MAX = (64'd1 << SAT_W) - 1;

    typedef struct {
        logic [31:0] exp_main;
        logic [31:0] exp_sat;
        string       tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wb_stb = 1'b0;
    logic              wb_we = 1'b0;
    logic [ADDR_W-1:0] wb_addr = '0;
    logic [NUM_IN-1:0] btn_raw = '0;
    logic [NUM_IN-1:0] btn_level = '0;
    logic              ack_main, ack_sat;
    logic [31:0]       rd_main, rd_sat;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    item_t sb_q[$];

    // bench model of the tallies
    longint m_trans = 0;
    longint m_first = 0;
    longint m_last  = 0;
    bit     m_started = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bounce_meter #(.NUM_IN(NUM_IN), .CNT_W(31), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .wb_stb(wb_stb), .wb_we(wb_we), .wb_addr(wb_addr),
        .btn_raw(btn_raw), .btn_level(btn_level), .wb_ack(ack_main), .wb_rdata(rd_main)
    );

    bounce_meter #(.NUM_IN(NUM_IN), .CNT_W(SAT_W), .ADDR_W(ADDR_W)) u_dut_sat (
        .clk(clk), .rst(rst), .wb_stb(wb_stb), .wb_we(wb_we), .wb_addr(wb_addr),
        .btn_raw(btn_raw), .btn_level(btn_level), .wb_ack(ack_sat), .wb_rdata(rd_sat)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sat_of(input longint v);
        return (v > SAT_MAX) ? 32'(SAT_MAX) : 32'(v);
    endfunction

    function automatic longint m_dur();
        return m_started ? (m_last - m_first) : 0;
    endfunction

    // driver: one strobed read, expected values pushed to the scoreboard
    task automatic bus_read(input int idx, input longint exp, input string tag);
        item_t it;
        it.exp_main = 32'(exp);
        it.exp_sat  = (idx == 6 || idx == 7) ? sat_of(exp) : 32'(exp);
        it.tag      = tag;
        sb_q.push_back(it);
        wb_stb  = 1'b1;
        wb_we   = 1'b0;
        wb_addr = ADDR_W'(idx);
        @(negedge clk);
        wb_stb  = 1'b0;
    endtask

    task automatic bus_write(input int idx, input string tag);
        item_t it;
        it.exp_main = 32'd0;
        it.exp_sat  = 32'd0;
        it.tag      = tag;
        sb_q.push_back(it);
        wb_stb  = 1'b1;
        wb_we   = 1'b1;
        wb_addr = ADDR_W'(idx);
        @(negedge clk);
        wb_stb  = 1'b0;
        wb_we   = 1'b0;
        if (idx == 6 || idx == 7) begin
            m_trans   = 0;
            m_started = 1'b0;
        end
    endtask

    // toggle the given raw bits, then wait gap cycles
    task automatic toggle(input logic [NUM_IN-1:0] mask, input int gap);
        btn_raw = btn_raw ^ mask;
        m_trans = m_trans + $countones(mask);
        if (!m_started) begin
            m_started = 1'b1;
            m_first   = cyc;
        end
        m_last = cyc;
        repeat (gap) @(negedge clk);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // monitor: pops scoreboard items when acknowledges appear
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (ack_main != ack_sat) begin
                check(1'b0, "R7 ack mismatch between instances", 32'(ack_sat), 32'(ack_main));
            end
            if (ack_main) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7 acknowledge without strobe", 32'd1, 32'd0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(rd_main == it.exp_main, it.tag, rd_main, it.exp_main);
                    check(rd_sat == it.exp_sat, {it.tag, " (4-bit tallies)"}, rd_sat, it.exp_sat);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        btn_level = 4'b1010;
        repeat (4) @(negedge clk);
        // R1 reset state at the ports
        check(ack_main == 1'b0, "R1 ack low in reset", 32'(ack_main), 32'd0);
        check(rd_main == 32'd0, "R1 rdata zero in reset", rd_main, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        bus_read(6, 0, "R1 transition tally zero after reset");
        bus_read(7, 0, "R1 duration tally zero after reset");

        // R2/R3: bounces on one line, spacing 5 then 7 clocks
        toggle(4'b0001, 5);
        toggle(4'b0001, 7);
        toggle(4'b0001, 1);
        settle();
        bus_read(6, m_trans, "R2 three single-bit changes");
        bus_read(7, m_dur(), "R3 first-to-last spacing 12");

        // R2: several bits in one cycle each count
        toggle(4'b1110, 3);
        settle();
        bus_read(6, m_trans, "R2 three bits changing together");
        bus_read(7, m_dur(), "R3 duration extended by later change");

        // R4: unrelated write leaves tallies alone
        bus_write(3, "R7 write acknowledge data zero");
        bus_read(6, m_trans, "R4 write to index 3 keeps transitions");
        bus_read(7, m_dur(), "R4 write to index 3 keeps duration");

        // R4: write to duration word clears both
        bus_write(7, "R7 write acknowledge data zero");
        bus_read(6, 0, "R4 clear via index 7 zeroes transitions");
        bus_read(7, 0, "R4 clear via index 7 zeroes duration");

        // R3: single change after clear gives zero duration
        toggle(4'b0100, 1);
        settle();
        bus_read(6, m_trans, "R2 single change after clear");
        bus_read(7, 0, "R3 single change duration zero");

        // R5 / R6 register map
        bus_read(8, 32'hA, "R5 debounced levels zero-extended");
        btn_level = 4'b0111;
        @(negedge clk);
        bus_read(8, 32'h7, "R5 debounced levels follow input");
        bus_read(0, 0, "R6 index 0 reads zero");
        bus_read(5, 0, "R6 index 5 reads zero");
        bus_read(9, 0, "R6 index 9 reads zero");
        bus_read(15, 0, "R6 index 15 reads zero");

        // back-to-back strobes: R7 data per strobe
        bus_read(6, m_trans, "R7 back-to-back read first");
        bus_read(8, 32'h7, "R7 back-to-back read second");

        // R8: clear via index 6, then push past the 4-bit limit
        bus_write(6, "R7 write acknowledge data zero");
        bus_read(7, 0, "R4 clear via index 6 zeroes duration");
        for (int i = 0; i < 20; i++) begin
            toggle(4'b0001, 2);
        end
        settle();
        bus_read(6, m_trans, "R8 transition tally saturates");
        bus_read(7, m_dur(), "R8 duration tally saturates");

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R7 every strobe acknowledged", 32'(sb_q.size()), 32'd0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule